// File: doc/BRIEF.md
# Memory-Mapped Word Messaging Network Port

This block sits on a small processor's load/store bus as a slave and connects it to a packet network. Two adjacent word addresses carry the whole exchange. The data register holds the outgoing 32-bit word on writes and returns the last word received on reads. The status register carries the destination node, a send request bit, and two read-only flags. One flag says whether a new send can be accepted. The other says whether a received word is waiting.

To send, software writes the word to the data register. It then writes the status register with the destination node and the request bit set. The block turns the word into a three-flit packet and drives it onto its injection port under a valid/ready handshake. On the ejection side, it rebuilds incoming packets into a word and raises the receive flag. It holds that word until software reads the data register. While the word is unread, the block stalls the final flit of the next packet on the link. It does not buffer it.

Top module: `mmio_net_if`

## Requirements
- R1: After reset, the status register reads 0x00000002 (send-ready set, receive-valid clear, destination 0), the data register reads 0, `tx_valid` is low and `rx_ready` is high.
- R2: A write to the data register at 0x08000000 sets the outgoing word. A read of that address returns the most recently received word.
- R3: The status register at 0x08000004 has the send request at bit 0 (always reads 0), send-ready at bit 1, receive-valid at bit 2 and the destination node at bits [15:8]. All other bits read 0. Every write to it loads the destination field.
- R4: A flit is 18 bits: bit 17 marks a head, bit 16 marks a tail, and bits [15:0] carry the payload. A send produces exactly three flits. The first is a head flit with the destination in payload bits [7:0] and zeros in [15:8]. The second carries word bits [31:16]. The third carries word bits [15:0] and has the tail mark.
- R5: A flit offered on `tx_flit` stays unchanged while `tx_ready` is low. Send-ready falls in the cycle after an accepted request. With no stall, it rises again three cycles after the request, once the tail flit is taken.
- R6: A send request written while send-ready is 0 is ignored. No further packet is sent and the word is not queued. The packet already in flight keeps the word and destination it was started with.
- R7: Incoming head, upper and tail flits are assembled upper half first. Receive-valid goes to 1 when the tail is taken, and the word is then readable from the data register.
- R8: A data-register read while receive-valid is 1 clears the flag. Until that read, the held word stays unchanged and `rx_ready` is low whenever the next packet's tail flit would be taken.
- R9: Flits without the head mark that arrive while no packet is in progress are discarded.
- R10: `send_strobe` pulses for exactly one cycle per accepted send request and never for an ignored one. `tx_free` and `rx_avail` mirror status bits 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| send_strobe | output | 1 | Pulse on an accepted send request |
| tx_free | output | 1 | Send-ready flag |
| rx_avail | output | 1 | Receive-valid flag |
| tx_valid | output | 1 | Injection flit valid |
| tx_flit | output | 18 | Injection flit |
| tx_ready | input | 1 | Network accepts the injection flit |
| rx_valid | input | 1 | Ejection flit valid |
| rx_flit | input | 18 | Ejection flit |
| rx_ready | output | 1 | Block accepts the ejection flit |

## Verification
The bench aims at a send request that arrives while a packet is stalled on the link. A design that queued that request, or reloaded the in-flight word or destination, would emit a fourth flit or deliver the wrong word. It sends a second packet while the first word is still unread. A design without tail back-pressure would overwrite the held word, and one that did not clear the flag on read would deadlock. It injects stray non-head flits, which a careless unpacker would take as a packet start and so misalign the next word. It also checks the exact cycle send-ready returns and the half-word order of each flit, since a swapped order or a missing tail mark shows at once in the logged flits.

// File: rtl/net_if_pkg.sv
// Shared widths and flit layout for the memory-mapped network port.
// Assumes the word splits into a whole number of flit payloads.
package net_if_pkg;
    localparam int WORD_W      = 32;
    localparam int FLIT_DATA_W = 16;
    localparam int NODE_W      = 8;
    localparam int FLIT_W      = FLIT_DATA_W + 2;
    localparam int HEAD_BIT    = FLIT_W - 1;
    localparam int TAIL_BIT    = FLIT_W - 2;
    localparam int NUM_DFLITS  = WORD_W / FLIT_DATA_W;
    localparam int IDX_W       = (NUM_DFLITS > 1) ? $clog2(NUM_DFLITS) : 1;
    // status register bit positions
    localparam int ST_SEND_BIT = 0;
    localparam int ST_FREE_BIT = 1;
    localparam int ST_AVAIL_BIT = 2;
    localparam int ST_DEST_LSB = 8;

    typedef enum logic [1:0] {TX_IDLE, TX_HEAD, TX_DATA} tx_state_e;
    typedef enum logic       {RX_HEAD, RX_DATA} rx_state_e;
endpackage

// File: rtl/nif_regs.sv
// Bus decode and software-visible registers.
// Assumes single-cycle bus accesses. Read data is combinational from state.
module nif_regs
    import net_if_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] DATA_ADDR = 32'h0800_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              tx_free,
    input  logic              rx_avail,
    input  logic [WORD_W-1:0] rx_word,
    output logic              send_pulse,
    output logic [WORD_W-1:0] send_word,
    output logic [NODE_W-1:0] send_dest,
    output logic              rd_clear
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(DATA_ADDR + 32'd4);

    logic              hit_data, hit_stat;
    logic [WORD_W-1:0] word_q;
    logic [NODE_W-1:0] dest_q;
    logic [WORD_W-1:0] status;

    // address decode
    always_comb begin
        hit_data = bus_sel && (bus_addr == DATA_A);
        hit_stat = bus_sel && (bus_addr == STAT_A);
    end

    // outgoing word and destination registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            dest_q <= '0;
        end else begin
            if (hit_data && bus_we) word_q <= bus_wdata;
            if (hit_stat && bus_we) dest_q <= bus_wdata[ST_DEST_LSB +: NODE_W];
        end
    end

    // send request and read-clear strobes
    always_comb begin
        send_pulse = hit_stat && bus_we && bus_wdata[ST_SEND_BIT] && tx_free;
        send_word  = word_q;
        send_dest  = bus_wdata[ST_DEST_LSB +: NODE_W];
        rd_clear   = hit_data && !bus_we && rx_avail;
    end

    // status word assembly and read mux
    always_comb begin
        status = '0;
        status[ST_DEST_LSB +: NODE_W] = dest_q;
        status[ST_FREE_BIT]  = tx_free;
        status[ST_AVAIL_BIT] = rx_avail;
        if (hit_data && !bus_we)      bus_rdata = rx_word;
        else if (hit_stat && !bus_we) bus_rdata = status;
        else                          bus_rdata = '0;
    end

    // a read of a waiting word leaves the flag clear on the next cycle
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clear |=> !rx_avail);
endmodule

// File: rtl/nif_tx_packer.sv
// Splits one word into a head flit and data flits, upper half first.
// Assumes start is only raised while tx_free is high.
module nif_tx_packer
    import net_if_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] start_word,
    input  logic [NODE_W-1:0] start_dest,
    output logic              tx_valid,
    output logic [FLIT_W-1:0] tx_flit,
    input  logic              tx_ready,
    output logic              tx_free
);
    tx_state_e               state;
    logic [IDX_W-1:0]        idx;
    logic [WORD_W-1:0]       word_q;
    logic [NODE_W-1:0]       dest_q;
    logic [FLIT_DATA_W-1:0]  slice;

    // sequence head then data flits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TX_IDLE;
            idx    <= '0;
            word_q <= '0;
            dest_q <= '0;
        end else begin
            case (state)
                TX_IDLE: if (start) begin
                    word_q <= start_word;
                    dest_q <= start_dest;
                    idx    <= IDX_W'(NUM_DFLITS - 1);
                    state  <= TX_HEAD;
                end
                TX_HEAD: if (tx_ready) state <= TX_DATA;
                TX_DATA: if (tx_ready) begin
                    if (idx == '0) state <= TX_IDLE;
                    else           idx   <= idx - IDX_W'(1);
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // flit formatting
    always_comb begin
        slice    = word_q[int'(idx)*FLIT_DATA_W +: FLIT_DATA_W];
        tx_valid = (state != TX_IDLE);
        tx_free  = (state == TX_IDLE);
        tx_flit  = '0;
        if (state == TX_HEAD) begin
            tx_flit[HEAD_BIT]        = 1'b1;
            tx_flit[0 +: NODE_W]     = dest_q;
        end else if (state == TX_DATA) begin
            tx_flit[TAIL_BIT]            = (idx == '0);
            tx_flit[0 +: FLIT_DATA_W]    = slice;
        end
    end

    assert_flit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_flit));
    assert_start_when_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> tx_free);
    assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !tx_free);
    assert_head_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_flit[HEAD_BIT]);
endmodule

// File: rtl/nif_rx_unpacker.sv
// Reassembles incoming packets into a word and holds it until read.
// Assumes well-formed packets; stray non-head flits between packets are dropped.
module nif_rx_unpacker
    import net_if_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [FLIT_W-1:0] rx_flit,
    output logic              rx_ready,
    input  logic              rd_clear,
    output logic              rx_avail,
    output logic [WORD_W-1:0] rx_word
);
    rx_state_e         state;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] asm_q;
    logic              take;
    logic              last;

    // back-pressure only the final flit while a word is unread
    always_comb begin
        last     = (state == RX_DATA) && (idx == '0);
        rx_ready = !(last && rx_avail);
        take     = rx_valid && rx_ready;
    end

    // packet assembly and held-word flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_HEAD;
            idx      <= '0;
            asm_q    <= '0;
            rx_word  <= '0;
            rx_avail <= 1'b0;
        end else begin
            if (rd_clear) rx_avail <= 1'b0;
            case (state)
                RX_HEAD: if (take && rx_flit[HEAD_BIT]) begin
                    idx   <= IDX_W'(NUM_DFLITS - 1);
                    state <= RX_DATA;
                end
                RX_DATA: if (take) begin
                    asm_q <= {asm_q[WORD_W-FLIT_DATA_W-1:0], rx_flit[0 +: FLIT_DATA_W]};
                    if (idx == '0) begin
                        rx_word  <= {asm_q[WORD_W-FLIT_DATA_W-1:0], rx_flit[0 +: FLIT_DATA_W]};
                        rx_avail <= 1'b1;
                        state    <= RX_HEAD;
                    end else begin
                        idx <= idx - IDX_W'(1);
                    end
                end
                default: state <= RX_HEAD;
            endcase
        end
    end

    assert_word_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail && !rd_clear |=> rx_avail && $stable(rx_word));
    assert_tail_marks_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take && last |-> rx_flit[TAIL_BIT]);
endmodule

// File: rtl/mmio_net_if.sv
// Top: bus slave registers plus flit packer and unpacker.
// Assumes one bus access per cycle at most and a valid/ready network link.
module mmio_net_if
    import net_if_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] DATA_ADDR = 32'h0800_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [net_if_pkg::WORD_W-1:0] bus_wdata,
    output logic [net_if_pkg::WORD_W-1:0] bus_rdata,
    output logic                          send_strobe,
    output logic                          tx_free,
    output logic                          rx_avail,
    output logic                          tx_valid,
    output logic [net_if_pkg::FLIT_W-1:0] tx_flit,
    input  logic                          tx_ready,
    input  logic                          rx_valid,
    input  logic [net_if_pkg::FLIT_W-1:0] rx_flit,
    output logic                          rx_ready
);
    logic [WORD_W-1:0] send_word, rx_word;
    logic [NODE_W-1:0] send_dest;
    logic              rd_clear;

    nif_regs #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_free(tx_free), .rx_avail(rx_avail), .rx_word(rx_word),
        .send_pulse(send_strobe), .send_word(send_word),
        .send_dest(send_dest), .rd_clear(rd_clear)
    );

    nif_tx_packer tx_i (
        .clk(clk), .rst_n(rst_n),
        .start(send_strobe), .start_word(send_word), .start_dest(send_dest),
        .tx_valid(tx_valid), .tx_flit(tx_flit), .tx_ready(tx_ready),
        .tx_free(tx_free)
    );

    nif_rx_unpacker rx_i (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_flit(rx_flit), .rx_ready(rx_ready),
        .rd_clear(rd_clear), .rx_avail(rx_avail), .rx_word(rx_word)
    );
endmodule

// File: tb/mmio_net_if_tb.sv
// Two ports linked back to back; a vector table of sends, then directed tests.
module mmio_net_if_tb_top;
    localparam logic [31:0] DA = 32'h0800_0000;
    localparam logic [31:0] SA = 32'h0800_0004;
    // {dest, word}
    localparam logic [39:0] VECS [6] = '{
        {8'h03, 32'hDEAD_BEEF}, {8'h00, 32'h0000_0000}, {8'hFF, 32'hFFFF_FFFF},
        {8'h5A, 32'h1234_5678}, {8'hA5, 32'h8000_0001}, {8'h01, 32'h0001_8000}};

    logic clk = 0, rst_n = 0;
    always #5 clk = ~clk;

    logic a_sel = 0, a_we = 0, b_sel = 0, b_we = 0;
    logic [31:0] a_addr = 0, a_wdata = 0, b_addr = 0, b_wdata = 0, a_rdata, b_rdata;
    logic a_send, a_free, a_avail, b_send, b_free, b_avail;
    logic a_txv, a_txr, a_rxv, a_rxr, b_txv, b_txr, b_rxv, b_rxr;
    logic [17:0] a_txf, a_rxf, b_txf, b_rxf;
    logic stall_ab = 0, inj_en = 0, inj_v = 0;
    logic [17:0] inj_f = 0;

    // behavioural link with stall and injection override
    assign b_rxv = inj_en ? inj_v : (a_txv & ~stall_ab);
    assign b_rxf = inj_en ? inj_f : a_txf;
    assign a_txr = ~inj_en & ~stall_ab & b_rxr;
    assign a_rxv = b_txv;
    assign a_rxf = b_txf;
    assign b_txr = a_rxr;

    mmio_net_if dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(a_sel), .bus_we(a_we),
        .bus_addr(a_addr), .bus_wdata(a_wdata), .bus_rdata(a_rdata),
        .send_strobe(a_send), .tx_free(a_free), .rx_avail(a_avail),
        .tx_valid(a_txv), .tx_flit(a_txf), .tx_ready(a_txr),
        .rx_valid(a_rxv), .rx_flit(a_rxf), .rx_ready(a_rxr));
    mmio_net_if peer_i (.clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_we(b_we),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(b_rdata),
        .send_strobe(b_send), .tx_free(b_free), .rx_avail(b_avail),
        .tx_valid(b_txv), .tx_flit(b_txf), .tx_ready(b_txr),
        .rx_valid(b_rxv), .rx_flit(b_rxf), .rx_ready(b_rxr));

    int nchk = 0, nfail = 0, cyc = 0, fcnt = 0, spc = 0;
    logic [17:0] flog [0:255];

    // monitor flits leaving dut_i and its send strobes
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && a_txv && a_txr) begin
            flog[fcnt[7:0]] <= a_txf;
            fcnt <= fcnt + 1;
        end
        if (rst_n && a_send) spc <= spc + 1;
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    // watchdog
    always @(negedge clk) if (cyc > 100000) begin
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [17:0] mkf(input logic h, input logic t, input logic [15:0] d);
        return {h, t, d};
    endfunction

    task automatic bwr(input bit side, input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        if (!side) begin a_sel = 1; a_we = 1; a_addr = addr; a_wdata = data; end
        else       begin b_sel = 1; b_we = 1; b_addr = addr; b_wdata = data; end
        @(negedge clk);
        a_sel = 0; a_we = 0; b_sel = 0; b_we = 0;
    endtask

    task automatic brd(input bit side, input logic [31:0] addr, output logic [31:0] d);
        @(negedge clk);
        if (!side) begin a_sel = 1; a_we = 0; a_addr = addr; end
        else       begin b_sel = 1; b_we = 0; b_addr = addr; end
        #1 d = side ? b_rdata : a_rdata;
        @(negedge clk);
        a_sel = 0; b_sel = 0;
    endtask

    task automatic wait_avail(input bit side, input string req);
        int n = 0;
        while (((side ? b_avail : a_avail) !== 1'b1) && n < 100) begin
            @(negedge clk); n++;
        end
        chk(req, "receive flag arrives", 32'(side ? b_avail : a_avail), 1);
    endtask

    initial begin
        logic [31:0] d;
        int f0, s0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", "tx_free", 32'(a_free), 1);
        chk("R1", "rx_avail", 32'(a_avail), 0);
        chk("R1", "tx_valid", 32'(a_txv), 0);
        chk("R1", "rx_ready", 32'(a_rxr), 1);
        brd(0, SA, d); chk("R1", "status reset", d, 32'h2);
        brd(0, DA, d); chk("R1", "data reset", d, 32'h0);

        // vector table: dut_i sends to peer_i
        foreach (VECS[i]) begin
            logic [7:0] dst; logic [31:0] w;
            dst = VECS[i][39:32]; w = VECS[i][31:0];
            f0 = fcnt; s0 = spc;
            bwr(0, DA, w);
            bwr(0, SA, {16'h0, dst, 8'h01});
            wait_avail(1, "R7");
            chk("R4", "flit count", 32'(fcnt - f0), 3);
            chk("R4", "head flit", 32'(flog[f0]), 32'(mkf(1, 0, {8'h00, dst})));
            chk("R4", "upper flit", 32'(flog[f0+1]), 32'(mkf(0, 0, w[31:16])));
            chk("R4", "tail flit", 32'(flog[f0+2]), 32'(mkf(0, 1, w[15:0])));
            chk("R10", "one strobe", 32'(spc - s0), 1);
            brd(1, DA, d); chk("R2", "received word", d, w);
            brd(1, SA, d); chk("R8", "flag cleared by read", d & 32'h4, 0);
            brd(0, SA, d); chk("R3", "status layout", d, {16'h0, dst, 8'h02});
            chk("R10", "tx_free mirrors bit1", 32'(a_free), 32'(d[1]));
        end

        // R5 exact send-ready timing
        bwr(0, DA, 32'h0BAD_F00D);
        bwr(0, SA, 32'h0000_0701);
        chk("R5", "send_rdy low after request", 32'(a_free), 0);
        @(negedge clk); @(negedge clk);
        chk("R5", "send_rdy still low", 32'(a_free), 0);
        @(negedge clk);
        chk("R5", "send_rdy back after tail", 32'(a_free), 1);
        chk("R7", "peer flag at tail", 32'(b_avail), 1);
        brd(1, DA, d); chk("R7", "word", d, 32'h0BAD_F00D);

        // R3 write without request only loads destination
        f0 = fcnt; s0 = spc;
        bwr(0, SA, 32'hFFFF_AB00);
        brd(0, SA, d); chk("R3", "dest only", d, 32'h0000_AB02);
        chk("R3", "no packet", 32'(fcnt - f0), 0);
        chk("R10", "no strobe", 32'(spc - s0), 0);

        // R6 request while busy is ignored; R5 flit held during stall
        stall_ab = 1;
        f0 = fcnt;
        bwr(0, DA, 32'h1111_2222);
        bwr(0, SA, 32'h0000_2201);
        s0 = spc;
        chk("R5", "held head", 32'(a_txf), 32'(mkf(1, 0, 16'h0022)));
        bwr(0, DA, 32'h3333_4444);
        bwr(0, SA, 32'h0000_3301);
        chk("R5", "head stable in stall", 32'(a_txf), 32'(mkf(1, 0, 16'h0022)));
        chk("R6", "no strobe when busy", 32'(spc - s0), 0);
        stall_ab = 0;
        wait_avail(1, "R6");
        brd(1, DA, d); chk("R6", "in-flight word kept", d, 32'h1111_2222);
        repeat (10) @(negedge clk);
        chk("R6", "no queued packet", 32'(fcnt - f0), 3);
        chk("R6", "head dest kept", 32'(flog[f0]), 32'(mkf(1, 0, 16'h0022)));
        chk("R6", "peer idle", 32'(b_avail), 0);

        // R8 tail back-pressure while the word is unread
        f0 = fcnt;
        bwr(0, DA, 32'hAAAA_0001);
        bwr(0, SA, 32'h0000_0501);
        wait_avail(1, "R8");
        bwr(0, DA, 32'hBBBB_0002);
        bwr(0, SA, 32'h0000_0501);
        repeat (8) @(negedge clk);
        chk("R8", "tail stalled", 32'(fcnt - f0), 5);
        chk("R8", "rx_ready low", 32'(b_rxr), 0);
        chk("R8", "sender busy", 32'(a_free), 0);
        brd(1, SA, d); chk("R8", "flag still set", d & 32'h4, 32'h4);
        brd(1, DA, d); chk("R8", "first word intact", d, 32'hAAAA_0001);
        wait_avail(1, "R8");
        brd(1, DA, d); chk("R8", "second word", d, 32'hBBBB_0002);

        // R9 stray non-head flits are discarded
        inj_en = 1;
        @(negedge clk); inj_v = 1; inj_f = mkf(0, 1, 16'hBAD0);
        @(negedge clk); inj_f = mkf(0, 0, 16'hBAD1);
        @(negedge clk); inj_v = 0;
        chk("R9", "no word from strays", 32'(b_avail), 0);
        inj_v = 1; inj_f = mkf(1, 0, 16'h0009);
        @(negedge clk); inj_f = mkf(0, 0, 16'hCAFE);
        @(negedge clk); inj_f = mkf(0, 1, 16'hF00D);
        @(negedge clk); inj_v = 0; inj_en = 0;
        chk("R9", "flag after packet", 32'(b_avail), 1);
        brd(1, DA, d); chk("R9", "aligned word", d, 32'hCAFE_F00D);

        // R7 reverse direction
        bwr(1, DA, 32'h5566_7788);
        bwr(1, SA, 32'h0000_0001);
        wait_avail(0, "R7");
        chk("R10", "rx_avail mirrors bit2", 32'(a_avail), 1);
        brd(0, DA, d); chk("R7", "reverse word", d, 32'h5566_7788);

        finish_run();
    end
endmodule